// File: doc/BRIEF.md
# Multiplexed Expansion Bus Address Driver

This block drives the address for an expansion bus whose eight address pins are shared by two kinds of target: a static RAM and a boot memory. Each access begins with the high part of the address on the pins. An address strobe then rises so that an external flip-flop can hold that high part. For the rest of the access the same pins carry the low address byte, and the strobe stays high as the output enable.

Which bits form the high part depends on the target. A RAM access uses a 16-bit address, so bits [15:8] are sent. A boot access uses a 20-bit address, so bits [19:16] are sent on the low four pins. A requester starts an access with a level request and sees a one-cycle acknowledge in the last cycle of the access. The number of cycles in the low-byte phase is set per access. Between accesses the pins are forced to zero to save switching power.

Top module: `xbus_addr_drv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pins_o` is 0, `strobe_o` is 0 and `ack_o` is 0.
- R2: Whenever no access is in progress, all bits of `pins_o` are 0 and `strobe_o` is 0.
- R3: A request seen with `req_i`=1 in an accepting idle cycle starts an access. In the next cycle the high part of the address is on `pins_o` and `strobe_o` is 0. The address, the target type and the wait count are taken at acceptance, and later changes to those inputs have no effect on that access.
- R4: For a RAM access (`dev_boot_i`=0), the high part is `addr_i[15:8]` on `pins_o[7:0]`.
- R5: For a boot access (`dev_boot_i`=1), the high part is `addr_i[19:16]` on `pins_o[3:0]`, with `pins_o[7:4]`=0.
- R6: `strobe_o` rises in the second cycle of the access, and `pins_o` still holds the high part in that cycle.
- R7: From the third cycle of the access through the acknowledge cycle, `pins_o` equals `addr_i[7:0]` and `strobe_o` is 1. In the cycle after the acknowledge, the strobe is low and the pins are back to 0.
- R8: The low-byte phase lasts N cycles. N is the value of `wait_i` (1 to 15), and a value of 0 counts as 1. `ack_o` is 1 for exactly the last of these cycles.
- R9: A request in the cycle right after `ack_o` is ignored. A request held into the following cycle is accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held by the requester until `ack_o` |
| dev_boot_i | input | 1 | Target type: 1 = boot memory, 0 = RAM |
| addr_i | input | 20 | Byte address of the access |
| wait_i | input | 4 | Number of low-byte phase cycles (0 counts as 1) |
| ack_o | output | 1 | Last cycle of the access |
| pins_o | output | 8 | Shared address pins |
| strobe_o | output | 1 | Address strobe and output enable. Its rising edge is where the external latch captures the high part. |

## Verification
On every cycle, the assertions check four things: the pins and strobe stay quiet while idle, the pins do not move at the strobe's rising edge or during the low-byte phase, the acknowledge is a single pulse, and no access is accepted right after it. Only the bench's sweeps show that the right address bits reach the pins for each target type, that every wait count from 0 to 15 gives the right phase length, and that input changes after acceptance have no effect on the access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UPPER = 2'd1,
    ST_CAPT  = 2'd2,
    ST_LOW   = 2'd3
  } xbus_state_e;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_LOW   = 2'd2
  } pin_sel_e;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              accept_o,
  output logic              strobe_o,
  output logic              ack_o,
  output pin_sel_e          sel_o,
  output xbus_state_e       state_o
);

  xbus_state_e       state_q, state_d;
  logic              idle_q;
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  // an idle cycle only accepts if the cycle before it was also idle
  assign accept_o = (state_q == ST_IDLE) && idle_q && req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        state_d = ST_UPPER;
        cnt_d   = (wait_i == '0) ? WAIT_W'(1) : wait_i;
      end
      ST_UPPER: state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_LOW;
      ST_LOW: begin
        if (cnt_q == WAIT_W'(1)) state_d = ST_IDLE;
        else                     cnt_d   = cnt_q - WAIT_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= WAIT_W'(1);
      idle_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idle_q  <= (state_q == ST_IDLE);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_UPPER, ST_CAPT: sel_o = SEL_UPPER;
      ST_LOW:            sel_o = SEL_LOW;
      default:           sel_o = SEL_ZERO;
    endcase
  end

  assign strobe_o = (state_q == ST_CAPT) || (state_q == ST_LOW);
  assign ack_o    = (state_q == ST_LOW) && (cnt_q == WAIT_W'(1));
  assign state_o  = state_q;

  p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_cnt_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW) |-> (cnt_q != '0));

  p_no_accept_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !accept_o);

  p_idle_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (state_q == ST_IDLE) ##1 (state_q == ST_IDLE));

endmodule

// File: rtl/xbus_upper_sel.sv
module xbus_upper_sel #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PIN_W  = 8
) (
  input  logic              boot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PIN_W-1:0]  upper_o,
  output logic [PIN_W-1:0]  low_o
);

  localparam int unsigned BOOT_W = ADDR_W - 2 * PIN_W;

  logic [PIN_W-1:0] ram_hi;
  logic [PIN_W-1:0] boot_hi;

  assign ram_hi = addr_i[2*PIN_W-1:PIN_W];
  assign low_o  = addr_i[PIN_W-1:0];

  generate
    if (BOOT_W < PIN_W) begin : g_boot_pad
      assign boot_hi = {{(PIN_W - BOOT_W){1'b0}}, addr_i[ADDR_W-1:2*PIN_W]};
    end else begin : g_boot_full
      assign boot_hi = addr_i[2*PIN_W +: PIN_W];
    end
  endgenerate

  assign upper_o = boot_i ? boot_hi : ram_hi;

endmodule

// File: rtl/xbus_pin_mux.sv
module xbus_pin_mux
  import xbus_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  pin_sel_e         sel_i,
  input  logic [PIN_W-1:0] upper_i,
  input  logic [PIN_W-1:0] low_i,
  output logic [PIN_W-1:0] pins_o
);

  always_comb begin
    unique case (sel_i)
      SEL_UPPER: pins_o = upper_i;
      SEL_LOW:   pins_o = low_i;
      default:   pins_o = '0;
    endcase
  end

endmodule

// File: rtl/xbus_addr_drv.sv
module xbus_addr_drv
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dev_boot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ack_o,
  output logic [PIN_W-1:0]  pins_o,
  output logic              strobe_o
);

  logic              accept;
  pin_sel_e          sel;
  xbus_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic              boot_q;
  logic [PIN_W-1:0]  upper;
  logic [PIN_W-1:0]  low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      boot_q <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_i;
      boot_q <= dev_boot_i;
    end
  end

  xbus_seq #(.WAIT_W(WAIT_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wait_i  (wait_i),
    .accept_o(accept),
    .strobe_o(strobe_o),
    .ack_o   (ack_o),
    .sel_o   (sel),
    .state_o (state)
  );

  xbus_upper_sel #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) i_upper_sel (
    .boot_i (boot_q),
    .addr_i (addr_q),
    .upper_o(upper),
    .low_o  (low)
  );

  xbus_pin_mux #(.PIN_W(PIN_W)) i_pin_mux (
    .sel_i  (sel),
    .upper_i(upper),
    .low_i  (low),
    .pins_o (pins_o)
  );

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (pins_o == '0 && !strobe_o));

  p_upper_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (pins_o == upper && !strobe_o));

  p_strobe_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_UPPER) |=> (strobe_o && $stable(pins_o)));

  p_low_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOW && !ack_o) |=> (strobe_o && $stable(pins_o)));

endmodule

// File: tb/test_xbus_addr_drv.sv
`timescale 1ns/1ps
module test_xbus_addr_drv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        dev_boot = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  wait_n = '0;
  logic        ack;
  logic [7:0]  pins;
  logic        strobe;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  xbus_addr_drv i_xbus_addr_drv (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_i     (req),
    .dev_boot_i(dev_boot),
    .addr_i    (addr),
    .wait_i    (wait_n),
    .ack_o     (ack),
    .pins_o    (pins),
    .strobe_o  (strobe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // output vector packed as {ack, strobe, pins}
  function automatic int outv();
    return {22'd0, ack, strobe, pins};
  endfunction

  // entered just after a negedge, in an accepting idle cycle
  task automatic run_access(input logic boot, input logic [19:0] a, input int w);
    int n;
    int up;
    int lo;
    int exp;
    n  = (w == 0) ? 1 : w;
    up = boot ? int'((a >> 16) & 20'hF) : int'((a >> 8) & 20'hFF);
    lo = int'(a & 20'hFF);
    req = 1'b1; dev_boot = boot; addr = a; wait_n = 4'(w);
    chk(outv() == 0, "R2 idle before accept", outv(), 0);
    @(negedge clk);
    exp = up;
    chk(outv() == exp, boot ? "R5 boot upper, R3 start" : "R4 ram upper, R3 start", outv(), exp);
    // R3: inputs changed after acceptance must not affect this access
    addr = ~a; dev_boot = ~boot; wait_n = 4'(w) ^ 4'd5;
    @(negedge clk);
    exp = 256 | up;
    chk(outv() == exp, "R6 strobe rises over held upper", outv(), exp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp = ((i == n - 1) ? 512 : 0) | 256 | lo;
      chk(outv() == exp, "R7 low byte / R8 phase length and ack", outv(), exp);
    end
    @(negedge clk);
    chk(outv() == 0, "R7 strobe falls after ack", outv(), 0);
    @(negedge clk);
    chk(outv() == 0, "R9 request right after ack ignored", outv(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [19:0] a;
    repeat (3) @(negedge clk);
    chk(outv() == 0, "R1 outputs during reset", outv(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outv() == 0, "R1 outputs after reset", outv(), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(outv() == 0, "R2 idle without request", outv(), 0);
    end
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 16; w++) begin
        for (int k = 0; k < 3; k++) begin
          a = 20'h10101 | 20'((k * 20'h5A3C7 + w * 20'h0B1D3 + 20'h2E1B4) & 20'hFFFFF);
          run_access(b[0], a, w);
        end
      end
    end
    req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(outv() == 0, "R2 idle after last access", outv(), 0);
    end
    // accept after a gap with request low
    run_access(1'b0, 20'hABCDE, 2);
    req = 1'b0;
    @(negedge clk);
    chk(outv() == 0, "R2 idle at end", outv(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule